// File: doc/BRIEF.md
# Bus-Mapped Port Replacement Unit

This block is a 32-bit bus slave that sits behind a single chip select. It gives the host back two general-purpose I/O ports that it loses when its own pins carry the external address and data bus. It also gives the host memory-mapped access to an 8-bit character or graphic LCD module and to a keypad scanner. The host addresses the block with a byte offset and drives chip select until the block returns a one-cycle transfer acknowledge. The block ends every access itself and does not depend on wait-state counting in the host.

Register accesses finish one clock after chip select is seen. An LCD access drives the module's register address, direction and data, and holds its enable strobe for `LCD_EN_CYCLES` clocks. The acknowledge follows only after the strobe has ended. An offset that decodes to nothing gets no acknowledge, so the host's bus monitor times it out.

Top module: `port_repl_unit`

## Requirements
- R1: After reset, both pad output-enable buses are all zero, both pad output buses are zero, `ack_o` is 0 and `lcd_en_o` is 0.
- R2: An access to offset 0x10 through 0x2C raises `ack_o` for exactly one clock, in the cycle after the first clock edge that samples `cs_i` high. While `ack_o` is high, `cs_i` is ignored.
- R3: A write to offset 0x24 loads the D-port latch and a write to 0x28 loads the A/C-port latch. Bits 7:0 of the A/C port are the C group and bits 31:8 are the A group. Each pad output bus always shows its latch.
- R4: The direction register at offset 0x2C drives both output-enable buses: bit i = 1 enables pad bit i of both ports. A read of 0x2C returns the register.
- R5: A read of 0x24 or 0x28 returns, for each bit, the latch value where the direction bit is 1 and the live pad input where it is 0.
- R6: Offsets 0x00, 0x04, 0x08 and 0x0C select LCD register addresses 0, 1, 2 and 3 on `lcd_reg_o`. These are command 1, data 1, command 2 and data 2. `lcd_en_o` stays high for exactly `LCD_EN_CYCLES` clocks, and `ack_o` rises in the cycle after `lcd_en_o` falls, so the latency is `LCD_EN_CYCLES`+1 clocks. On a write, `lcd_rd_o` is 0, `lcd_data_oe_o` is 1 and `lcd_data_o` carries write-data bits 7:0.
- R7: On an LCD read, `lcd_rd_o` is 1. `rdata_o` bits 7:0 return `lcd_data_i` as sampled in the last strobe cycle, and bits 31:8 read as zero.
- R8: Offset 0x10 reads the keypad as follows: bits 4:0 hold the key number, bit 7 is 1 while a key is held, and all other bits are 0. Writes to 0x10 are acknowledged and change nothing.
- R9: Offsets 0x14, 0x18, 0x1C and 0x20 are acknowledged, read as zero and ignore writes.
- R10: Offsets above 0x2C, and any offset with bit 1 or bit 0 set, get no acknowledge and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, held by the host until acknowledge |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while ack_o is high |
| ack_o | output | 1 | Transfer acknowledge, one-cycle pulse |
| pad_d_i | input | 32 | D-port pad levels |
| pad_d_o | output | 32 | D-port pad drive values |
| pad_d_oe_o | output | 32 | D-port pad output enables |
| pad_ac_i | input | 32 | A/C-port pad levels |
| pad_ac_o | output | 32 | A/C-port pad drive values |
| pad_ac_oe_o | output | 32 | A/C-port pad output enables |
| lcd_reg_o | output | 2 | LCD module register address |
| lcd_rd_o | output | 1 | LCD direction, 1 = read |
| lcd_en_o | output | 1 | LCD enable strobe |
| lcd_data_o | output | 8 | LCD write data |
| lcd_data_oe_o | output | 1 | LCD data bus drive enable |
| lcd_data_i | input | 8 | LCD read data |
| key_code_i | input | 5 | Current or most recent key number |
| key_down_i | input | 1 | Key currently held |

## Verification
The assertions check, on every clock, these properties: the acknowledge stays a single-cycle pulse; it never overlaps the LCD strobe; the strobe ends only together with its completion; the LCD register address holds steady while the strobe is high; latches change only on their own write strobe; and an unmapped chip select is never acknowledged. The bench scenarios cover the rest. They check the read-data values: the mix of pad and latch per direction bit, the keypad layout, zero from reserved offsets, and LCD bytes. They also measure exact access latency and strobe length, and show that keypad, reserved, misaligned and unmapped writes leave the pads and readback unchanged.

// File: rtl/pru_pkg.sv
package pru_pkg;
  typedef enum logic [2:0] {
    SEL_LCD,
    SEL_KEY,
    SEL_RSVD,
    SEL_PD,
    SEL_PAC,
    SEL_DIR,
    SEL_NONE
  } sel_e;

  // word indices of the decoded window
  localparam int unsigned WI_KEY      = 4;
  localparam int unsigned WI_RSVD_LO  = 5;
  localparam int unsigned WI_RSVD_HI  = 8;
  localparam int unsigned WI_PD       = 9;
  localparam int unsigned WI_PAC      = 10;
  localparam int unsigned WI_DIR      = 11;
  localparam int unsigned NPORTS      = 2;
endpackage

// File: rtl/pru_addr_decode.sv
module pru_addr_decode
  import pru_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_e              sel_o,
  output logic [1:0]        lcd_reg_o
);
  localparam int unsigned WW = ADDR_W - 2;

  logic [WW-1:0] widx;
  assign widx      = addr_i[ADDR_W-1:2];
  assign lcd_reg_o = widx[1:0];

  always_comb begin
    if (addr_i[1:0] != 2'b00)              sel_o = SEL_NONE;
    else if (widx < WW'(WI_KEY))           sel_o = SEL_LCD;
    else if (widx == WW'(WI_KEY))          sel_o = SEL_KEY;
    else if (widx <= WW'(WI_RSVD_HI) &&
             widx >= WW'(WI_RSVD_LO))      sel_o = SEL_RSVD;
    else if (widx == WW'(WI_PD))           sel_o = SEL_PD;
    else if (widx == WW'(WI_PAC))          sel_o = SEL_PAC;
    else if (widx == WW'(WI_DIR))          sel_o = SEL_DIR;
    else                                   sel_o = SEL_NONE;
  end
endmodule

// File: rtl/pru_gpio_port.sv
module pru_gpio_port #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0] latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   latch_q <= '0;
    else if (wr_i) latch_q <= wdata_i;
  end

  assign pad_o   = latch_q;
  assign oe_o    = dir_i;
  assign rdata_o = (dir_i & latch_q) | (~dir_i & pad_i);

  // R3
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(pad_o));
endmodule

// File: rtl/pru_lcd_bridge.sv
module pru_lcd_bridge #(
  parameter int unsigned EN_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       rd_i,
  input  logic [1:0] reg_i,
  input  logic [7:0] wdata_i,
  input  logic [7:0] lcd_din_i,
  output logic       lcd_en_o,
  output logic       lcd_rd_o,
  output logic [1:0] lcd_reg_o,
  output logic [7:0] lcd_dout_o,
  output logic       lcd_doe_o,
  output logic       done_o,
  output logic [7:0] rdata_o
);
  localparam int unsigned CNT_W = $clog2(EN_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcd_en_o   <= 1'b0;
      lcd_rd_o   <= 1'b1;
      lcd_reg_o  <= '0;
      lcd_dout_o <= '0;
      done_o     <= 1'b0;
      rdata_o    <= '0;
      cnt_q      <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        lcd_en_o   <= 1'b1;
        lcd_rd_o   <= rd_i;
        lcd_reg_o  <= reg_i;
        lcd_dout_o <= wdata_i;
        cnt_q      <= '0;
      end else if (lcd_en_o) begin
        if (cnt_q == CNT_W'(EN_CYCLES - 1)) begin
          lcd_en_o <= 1'b0;
          done_o   <= 1'b1;
          rdata_o  <= lcd_din_i; // last strobe cycle
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign lcd_doe_o = lcd_en_o & ~lcd_rd_o;

  // R6
  en_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lcd_en_o) |-> done_o);
  // R6
  lcd_reg_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcd_en_o && $past(lcd_en_o)) |-> $stable(lcd_reg_o) && $stable(lcd_rd_o));
endmodule

// File: rtl/port_repl_unit.sv
module port_repl_unit
  import pru_pkg::*;
#(
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned LCD_EN_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              ack_o,
  input  logic [31:0]       pad_d_i,
  output logic [31:0]       pad_d_o,
  output logic [31:0]       pad_d_oe_o,
  input  logic [31:0]       pad_ac_i,
  output logic [31:0]       pad_ac_o,
  output logic [31:0]       pad_ac_oe_o,
  output logic [1:0]        lcd_reg_o,
  output logic              lcd_rd_o,
  output logic              lcd_en_o,
  output logic [7:0]        lcd_data_o,
  output logic              lcd_data_oe_o,
  input  logic [7:0]        lcd_data_i,
  input  logic [4:0]        key_code_i,
  input  logic              key_down_i
);
  localparam int unsigned DW = 32;

  sel_e        sel;
  logic [1:0]  dec_reg;
  logic        accept, reg_acc, lcd_start, lcd_done;
  logic        ack_q;
  logic [DW-1:0] dir_q, rdata_q, rd_mux;
  logic [7:0]  lcd_rdata;

  logic [NPORTS-1:0][DW-1:0] p_in, p_out, p_oe, p_rd;
  logic [NPORTS-1:0]         p_wr;

  pru_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i    (addr_i),
    .sel_o     (sel),
    .lcd_reg_o (dec_reg)
  );

  assign accept    = cs_i & ~ack_o & ~lcd_en_o;
  assign lcd_start = accept & (sel == SEL_LCD);
  assign reg_acc   = accept & (sel != SEL_LCD) & (sel != SEL_NONE);

  assign p_in[0] = pad_d_i;
  assign p_in[1] = pad_ac_i;
  assign p_wr[0] = reg_acc & we_i & (sel == SEL_PD);
  assign p_wr[1] = reg_acc & we_i & (sel == SEL_PAC);

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    pru_gpio_port #(.W(DW)) u_port (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (p_wr[g]),
      .wdata_i (wdata_i),
      .dir_i   (dir_q),
      .pad_i   (p_in[g]),
      .pad_o   (p_out[g]),
      .oe_o    (p_oe[g]),
      .rdata_o (p_rd[g])
    );
  end

  assign pad_d_o     = p_out[0];
  assign pad_d_oe_o  = p_oe[0];
  assign pad_ac_o    = p_out[1];
  assign pad_ac_oe_o = p_oe[1];

  pru_lcd_bridge #(.EN_CYCLES(LCD_EN_CYCLES)) u_lcd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (lcd_start),
    .rd_i       (~we_i),
    .reg_i      (dec_reg),
    .wdata_i    (wdata_i[7:0]),
    .lcd_din_i  (lcd_data_i),
    .lcd_en_o   (lcd_en_o),
    .lcd_rd_o   (lcd_rd_o),
    .lcd_reg_o  (lcd_reg_o),
    .lcd_dout_o (lcd_data_o),
    .lcd_doe_o  (lcd_data_oe_o),
    .done_o     (lcd_done),
    .rdata_o    (lcd_rdata)
  );

  always_comb begin
    unique case (sel)
      SEL_KEY: rd_mux = DW'({key_down_i, 2'b00, key_code_i});
      SEL_PD:  rd_mux = p_rd[0];
      SEL_PAC: rd_mux = p_rd[1];
      SEL_DIR: rd_mux = dir_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
      dir_q   <= '0;
    end else begin
      ack_q <= reg_acc;
      if (reg_acc) rdata_q <= rd_mux;
      if (reg_acc & we_i & (sel == SEL_DIR)) dir_q <= wdata_i;
    end
  end

  assign ack_o   = ack_q | lcd_done;
  assign rdata_o = lcd_done ? DW'(lcd_rdata) : rdata_q;

  // R2
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  // R6
  en_ack_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcd_en_o |-> !ack_o);
  // R10
  unmapped_no_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && sel == SEL_NONE && !ack_o && !lcd_en_o) |=> !ack_o);
  // R4
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && we_i && sel == SEL_DIR) |=> $stable(pad_d_oe_o));
endmodule

// File: tb/port_repl_unit_tb_top.sv
module port_repl_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int EN_CYC     = 4;
  localparam int ADDR_W     = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cs_i = 0, we_i = 0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic ack_o;
  logic [31:0] pad_d_i = '0, pad_d_o, pad_d_oe_o, pad_ac_i = '0, pad_ac_o, pad_ac_oe_o;
  logic [1:0] lcd_reg_o;
  logic lcd_rd_o, lcd_en_o, lcd_data_oe_o;
  logic [7:0] lcd_data_o, lcd_data_i = '0;
  logic [4:0] key_code_i = '0;
  logic key_down_i = 0;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] m_dir = '0, m_d = '0, m_ac = '0;
  bit in_acc = 0;
  int en_cnt = 0;
  logic [1:0] cap_reg;
  logic cap_rd, cap_oe;
  logic [7:0] cap_dout;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  port_repl_unit #(.ADDR_W(ADDR_W), .LCD_EN_CYCLES(EN_CYC)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-cycle reference comparison
  always begin
    @(negedge clk_i); #1;
    cyc++;
    if (rst_ni) begin
      chk(pad_d_oe_o == m_dir && pad_ac_oe_o == m_dir, "R4 oe", pad_d_oe_o, m_dir);
      chk(pad_d_o == m_d, "R3 pad_d", pad_d_o, m_d);
      chk(pad_ac_o == m_ac, "R3 pad_ac", pad_ac_o, m_ac);
      chk(!(ack_o && !in_acc), "R10 spurious ack", 32'(ack_o), 0);
    end
    if (cyc > 20000) begin
      chk(0, "watchdog", cyc, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk_i) if (lcd_en_o) begin
    en_cnt++;
    cap_reg = lcd_reg_o; cap_rd = lcd_rd_o; cap_dout = lcd_data_o; cap_oe = lcd_data_oe_o;
  end

  task automatic acc(input bit we, input logic [ADDR_W-1:0] a, input logic [31:0] wd,
                     input int maxw, output logic [31:0] rd, output int lat);
    lat = 0; rd = '0;
    @(negedge clk_i);
    in_acc = 1; en_cnt = 0;
    cs_i = 1; we_i = we; addr_i = a; wdata_i = wd;
    for (int n = 0; n < maxw; n++) begin
      @(negedge clk_i);
      if (ack_o) begin
        rd = rdata_o; lat = n + 1;
        if (we && a == 8'h24) m_d = wd;
        if (we && a == 8'h28) m_ac = wd;
        if (we && a == 8'h2C) m_dir = wd;
        break;
      end
    end
    cs_i = 0; we_i = 0;
    @(negedge clk_i);
    in_acc = 0;
  endtask

  initial begin
    logic [31:0] rd;
    int lat;
    repeat (3) @(negedge clk_i);
    // R1
    chk(pad_d_oe_o == 0 && pad_ac_oe_o == 0, "R1 oe", pad_d_oe_o | pad_ac_oe_o, 0);
    chk(pad_d_o == 0 && pad_ac_o == 0, "R1 pad", pad_d_o | pad_ac_o, 0);
    chk(!ack_o && !lcd_en_o, "R1 ack/en", {ack_o, lcd_en_o}, 0);
    rst_ni = 1;

    acc(1, 8'h2C, 32'h0000FFFF, 5, rd, lat);
    chk(lat == 1, "R2 latency", lat, 1);
    acc(0, 8'h2C, 0, 5, rd, lat);
    chk(rd == 32'h0000FFFF, "R4 dir readback", rd, 32'h0000FFFF);

    acc(1, 8'h24, 32'hDEADBEEF, 5, rd, lat);
    pad_d_i = 32'h12345678;
    acc(0, 8'h24, 0, 5, rd, lat);
    chk(rd == 32'h1234BEEF, "R5 pd mix", rd, 32'h1234BEEF);
    acc(1, 8'h28, 32'hCAFEF00D, 5, rd, lat);
    pad_ac_i = 32'h0;
    acc(0, 8'h28, 0, 5, rd, lat);
    chk(rd == 32'h0000F00D, "R5 pac mix", rd, 32'h0000F00D);
    acc(1, 8'h2C, 32'hFFFFFFFF, 5, rd, lat);
    acc(0, 8'h28, 0, 5, rd, lat);
    chk(rd == 32'hCAFEF00D, "R5 pac out", rd, 32'hCAFEF00D);
    acc(1, 8'h2C, 32'h0, 5, rd, lat);
    pad_d_i = 32'hA5A5_0F0F;
    acc(0, 8'h24, 0, 5, rd, lat);
    chk(rd == 32'hA5A5_0F0F, "R5 pd in", rd, 32'hA5A5_0F0F);
    acc(1, 8'h2C, 32'hFFFF0000, 5, rd, lat);

    // R8 keypad
    key_code_i = 5'd19; key_down_i = 1;
    acc(1, 8'h10, 32'hFFFFFFFF, 5, rd, lat);
    chk(lat == 1, "R8 write ack", lat, 1);
    acc(0, 8'h10, 0, 5, rd, lat);
    chk(rd == 32'h93, "R8 key held", rd, 32'h93);
    key_code_i = 5'd3; key_down_i = 0;
    acc(0, 8'h10, 0, 5, rd, lat);
    chk(rd == 32'h03, "R8 key released", rd, 32'h03);

    // R9 reserved
    for (int i = 0; i < 4; i++) begin
      acc(1, 8'(8'h14 + 4*i), 32'hFFFFFFFF, 5, rd, lat);
      chk(lat == 1, "R9 write ack", lat, 1);
      acc(0, 8'(8'h14 + 4*i), 0, 5, rd, lat);
      chk(rd == 0 && lat == 1, "R9 read zero", rd, 0);
    end
    acc(0, 8'h2C, 0, 5, rd, lat);
    chk(rd == 32'hFFFF0000, "R9 dir intact", rd, 32'hFFFF0000);

    // R10 unmapped and misaligned
    acc(1, 8'h30, 32'h0, 10, rd, lat);
    chk(lat == 0, "R10 0x30 no ack", lat, 0);
    acc(1, 8'hFC, 32'h0, 10, rd, lat);
    chk(lat == 0, "R10 0xFC no ack", lat, 0);
    acc(1, 8'h25, 32'h0, 10, rd, lat);
    chk(lat == 0, "R10 misaligned no ack", lat, 0);
    acc(0, 8'h24, 0, 5, rd, lat);
    chk(rd == {16'hDEAD, 16'h0F0F}, "R10 pd intact", rd, {16'hDEAD, 16'h0F0F});

    // R6 LCD writes, R7 LCD reads
    for (int r = 0; r < 4; r++) begin
      acc(1, 8'(4*r), 32'hFFFFFF40 + 32'(r), 20, rd, lat);
      chk(lat == EN_CYC + 1, "R6 write latency", lat, EN_CYC + 1);
      chk(en_cnt == EN_CYC, "R6 strobe length", en_cnt, EN_CYC);
      chk(cap_reg == 2'(r) && !cap_rd && cap_oe, "R6 reg/dir", {cap_reg, cap_rd, cap_oe}, {2'(r), 2'b01});
      chk(cap_dout == 8'h40 + 8'(r), "R6 write data", cap_dout, 8'h40 + 8'(r));
      lcd_data_i = 8'hA0 + 8'(r);
      acc(0, 8'(4*r), 0, 20, rd, lat);
      chk(lat == EN_CYC + 1 && cap_rd && !cap_oe && cap_reg == 2'(r), "R7 read cycle", lat, EN_CYC + 1);
      chk(rd == 32'hA0 + 32'(r), "R7 read data", rd, 32'hA0 + 32'(r));
    end

    repeat (2) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule